// File: doc/BRIEF.md
# Pulse-Count Burst Decoder

This block watches one asynchronous serial line for short bursts of pulses and counts the rising edges in each burst. A burst is over once the line has stayed low for a set number of clock cycles. The block then decodes the count: a burst of one, two or three pulses drives the matching one of three select outputs high. That output stays high for a long hold period, then drops, and the block clears its counter so that it is ready for the next burst.

All timing is set in clock cycles. `IDLE_CYCLES` is the end-of-burst silence and defaults to 5 ms at 100 MHz. `HOLD_CYCLES` is the output stretch and defaults to 3 s at 100 MHz. Bursts whose count has no matching output are discarded without any output. Edges that arrive while an output is held are not counted.

Top module: `pulse_burst_decoder`

## Requirements
- R1: While `rst` is high, `sel_out` is all zero, the pulse count is cleared and the block is idle. This holds even when reset arrives in the middle of a hold period: the output is low at the first clock edge with `rst` high.
- R2: At most one bit of `sel_out` is high at any time.
- R3: A burst of N pulses, with N from 1 to `NUM_OUT`, drives `sel_out[N-1]` high. One pulse gives 3'b001, two give 3'b010 and three give 3'b100.
- R4: `pulse_in` passes through a two-flop synchronizer. The selected output rises on the clock edge that takes the synchronized line's `IDLE_CYCLES`-th consecutive low sample. Counted from the first edge that samples the final falling input, this is edge `IDLE_CYCLES`+2, and `sel_out` is zero on all edges before it.
- R5: A high level restarts the idle timeout. A low gap of `IDLE_CYCLES`-1 cycles between pulses continues the burst. A pulse that stays high for longer than `IDLE_CYCLES` still counts as one pulse.
- R6: The selected output stays high for exactly `HOLD_CYCLES` clock cycles and then returns to zero.
- R7: A burst with more than `NUM_OUT` pulses produces no output. The block returns to idle, and the next valid burst is decoded normally.
- R8: Rising edges during a hold do not change the held output and are not counted. This includes an edge that is recognised on the same clock edge on which the hold ends. Counting resumes only with a new rising edge after the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous serial pulse line |
| sel_out | output | NUM_OUT | One-hot registered pattern select, high for the hold period |

## Verification
Two coincidences are provoked. In the first, a rising edge is timed so that the synchronized edge is recognised on the exact cycle at which the hold timer expires. The output must fall on schedule. The line is then left high and later low for longer than the timeout, and no new output may appear, which shows that the edge was dropped rather than counted into a fresh burst.

In the second, an inter-pulse gap sits one cycle short of the timeout. The restart and the expiry then fall on adjacent cycles, and the result is judged by whether the two pulses decode as a single two-pulse burst.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } pbd_state_t;
endpackage

// File: rtl/pbd_sync_edge.sv
module pbd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pbd_timer.sv
module pbd_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  assign done = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      if (done) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R6
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(LIMIT));
endmodule

// File: rtl/pbd_pulse_counter.sv
module pbd_pulse_counter #(
  parameter int NUM_OUT = 3,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] SAT = CW'(NUM_OUT + 1);

  always_ff @(posedge clk) begin
    if (rst || clear)               count <= '0;
    else if (inc && (count != SAT)) count <= count + 1'b1;
  end

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    count <= SAT);
endmodule

// File: rtl/pbd_decode.sv
module pbd_decode #(
  parameter int NUM_OUT = 3,
  parameter int CW      = 3
) (
  input  logic [CW-1:0]      count,
  output logic [NUM_OUT-1:0] onehot,
  output logic               valid
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_dec
    assign onehot[i] = (count == CW'(i + 1));
  end
  assign valid = |onehot;
endmodule

// File: rtl/pulse_burst_decoder.sv
module pulse_burst_decoder
  import pbd_pkg::*;
#(
  parameter int NUM_OUT     = 3,
  parameter int IDLE_CYCLES = 500_000,
  parameter int HOLD_CYCLES = 300_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_in,
  output logic [NUM_OUT-1:0] sel_out
);
  localparam int CW = $clog2(NUM_OUT + 2);

  pbd_state_t         state;
  logic               level, rise;
  logic               idle_done, hold_done;
  logic               cnt_inc, cnt_clear;
  logic [CW-1:0]      count;
  logic [NUM_OUT-1:0] dec_onehot;
  logic               dec_valid;
  logic [NUM_OUT-1:0] out_q;

  pbd_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(pulse_in), .level(level), .rise(rise)
  );

  pbd_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk(clk), .rst(rst),
    .clear(level || (state != ST_COUNT)),
    .run((state == ST_COUNT) && !level),
    .done(idle_done)
  );

  pbd_timer #(.LIMIT(HOLD_CYCLES)) u_hold_tmr (
    .clk(clk), .rst(rst),
    .clear(state != ST_HOLD),
    .run(state == ST_HOLD),
    .done(hold_done)
  );

  pbd_pulse_counter #(.NUM_OUT(NUM_OUT), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .inc(cnt_inc), .count(count)
  );

  pbd_decode #(.NUM_OUT(NUM_OUT), .CW(CW)) u_dec (
    .count(count), .onehot(dec_onehot), .valid(dec_valid)
  );

  always_comb begin
    cnt_inc   = rise && (state != ST_HOLD);
    cnt_clear = 1'b0;
    case (state)
      ST_COUNT: cnt_clear = !rise && idle_done && !dec_valid;
      ST_HOLD:  cnt_clear = hold_done;
      default:  cnt_clear = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      out_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rise) state <= ST_COUNT;
        end
        ST_COUNT: begin
          if (!rise && idle_done) begin
            if (dec_valid) begin
              out_q <= dec_onehot;
              state <= ST_HOLD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            out_q <= '0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_out = out_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_q == '0 && state == ST_IDLE && count == '0));
  // R2
  onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_q));
  // R4
  rise_from_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|out_q) |-> $past(state) == ST_COUNT);
  // R8
  hold_count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !hold_done) |=> $stable(count) && $stable(out_q));
  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && hold_done) |=> (out_q == '0 && count == '0));
endmodule

// File: tb/pulse_burst_decoder_bench.sv
module pulse_burst_decoder_bench;
  localparam int IDLE = 8;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [2:0] sel;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pulse_burst_decoder #(.NUM_OUT(3), .IDLE_CYCLES(IDLE), .HOLD_CYCLES(HOLD))
    u_pulse_burst_decoder (.clk(clk), .rst(rst), .pulse_in(din), .sel_out(sel));

  task automatic check(string req, logic [2:0] exp);
    checks++;
    if (sel !== exp || $countones(sel) > 1) begin
      errors++;
      $display("FAIL %s: sel_out=%b expected %b at %0t", req, sel, exp, $time);
    end
  endtask

  task automatic burst(int n, int hi, int gap);
    for (int p = 0; p < n; p++) begin
      din = 1'b1;
      repeat (hi) @(negedge clk);
      din = 1'b0;
      if (p < n - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic expect_decode(string req, logic [2:0] exp);
    repeat (IDLE + 1) @(negedge clk);
    check(req, 3'b000);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic expect_hold(logic [2:0] exp);
    repeat (HOLD - 1) @(negedge clk);
    check("R6", exp);
    @(negedge clk);
    check("R6", 3'b000);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    din = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 3'b000);
    din = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 3'b000);
  endtask

  task automatic t_counts();
    burst(1, 1, 1); expect_decode("R3/R4 one", 3'b001); expect_hold(3'b001);
    burst(2, 1, 2); expect_decode("R3/R4 two", 3'b010); expect_hold(3'b010);
    burst(3, 2, 2); expect_decode("R3/R4 three", 3'b100); expect_hold(3'b100);
  endtask

  task automatic t_restart();
    burst(1, IDLE + 4, 1); expect_decode("R5 long pulse", 3'b001); expect_hold(3'b001);
    burst(2, 1, IDLE - 1); expect_decode("R5 gap boundary", 3'b010); expect_hold(3'b010);
  endtask

  task automatic t_too_many();
    burst(5, 1, 2);
    repeat (IDLE + 2) @(negedge clk);
    check("R7 no output", 3'b000);
    repeat (5) @(negedge clk);
    check("R7 no output", 3'b000);
    burst(1, 1, 1); expect_decode("R7 recover", 3'b001); expect_hold(3'b001);
  endtask

  task automatic t_hold_ignore();
    burst(3, 1, 2);
    expect_decode("R8 setup", 3'b100);
    din = 1'b1; repeat (2) @(negedge clk);
    din = 1'b0; repeat (2) @(negedge clk);
    check("R8 pulse in hold", 3'b100);
    repeat (HOLD - 7) @(negedge clk);
    din = 1'b1;
    @(negedge clk); check("R8", 3'b100);
    @(negedge clk); check("R8", 3'b100);
    @(negedge clk); check("R8 edge at hold end", 3'b000);
    repeat (4) @(negedge clk);
    din = 1'b0;
    repeat (IDLE + 6) @(negedge clk);
    check("R8 edge not counted", 3'b000);
    burst(2, 1, 1); expect_decode("R8 resume", 3'b010); expect_hold(3'b010);
  endtask

  task automatic t_reset_in_hold();
    burst(1, 1, 1);
    expect_decode("R1 setup", 3'b001);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset in hold", 3'b000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    burst(3, 1, 1); expect_decode("R1 after reset", 3'b100); expect_hold(3'b100);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_counts();
    t_restart();
    t_too_many();
    t_hold_ignore();
    t_reset_in_hold();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end
endmodule